// File: doc/BRIEF.md
# Timer clock source selector

This block decides when a 16-bit timer/counter advances. A 3-bit source code picks one of eight behaviours: halted, counting on every system clock, counting on one of four fixed power-of-two divisions of the system clock, or counting on a chosen transition of an external pin. The result is a registered, single-cycle count-enable strobe that the counter uses as its increment qualifier. The counter, compare and waveform logic sit outside this block.

The divided rates come from a free-running 10-bit prescaler counter. A divide-by-N tap fires when the low log2(N) counter bits are all ones. A synchronous prescaler clear input forces the counter to zero and masks the taps while it is held. The external pin is always watched, whatever its drive direction and whatever source is selected. It passes through a two-flop synchronizer into a two-state level tracker. The states are `LVL_LOW` and `LVL_HIGH`. The transition `LVL_LOW -> LVL_HIGH` raises the rise event. The transition `LVL_HIGH -> LVL_LOW` raises the fall event. When the synchronized level matches the state, the tracker stays where it is and raises no event.

The source codes are `SRC_OFF` (000), `SRC_DIRECT` (001), `SRC_DIV8` (010), `SRC_DIV64` (011), `SRC_DIV256` (100), `SRC_DIV1024` (101), `SRC_PIN_FALL` (110) and `SRC_PIN_RISE` (111).

Top module: `tmr_clk_sel`

## Requirements
- R1: With source code 000, `cnt_en` stays low, whatever the pin does.
- R2: With source code 001, `cnt_en` is high in every cycle that follows a clock edge at which the code was 001.
- R3: With source code 010, `cnt_en` pulses once every 8 cycles. The first pulse appears 8 clock edges after the edge that cleared the prescaler.
- R4: Source codes 011, 100 and 101 give one pulse every 64, 256 and 1024 cycles respectively. Each first pulse appears N edges after the prescaler clear.
- R5: With source code 110, each high-to-low pin transition gives exactly one pulse. The pulse is high in the cycle after the third clock edge that follows the pin change. Low-to-high transitions give nothing.
- R6: With source code 111, each low-to-high pin transition gives exactly one pulse, with the same three-edge latency. High-to-low transitions give nothing.
- R7: The pin level tracker runs under every source code. A switch into an edge mode while the pin already rests at the new level produces no pulse.
- R8: While `psc_clr` is high, the prescaler holds at zero and no divided pulse is produced.
- R9: A qualifying event yields at most one pulse. A one-cycle pin pulse still gives exactly one count.
- R10: While `rst_n` is low, `cnt_en` is low, the prescaler is zero and the tracker is in `LVL_LOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_clr | input | 1 | Synchronous prescaler clear |
| src_sel | input | 3 | Count source code |
| ext_pin | input | 1 | Raw external pin level (asynchronous) |
| cnt_en | output | 1 | Registered single-cycle count-enable strobe |

## Verification
The bench measures the distance from a prescaler clear to the first pulse for every divider. An off-by-one tap mask or an unregistered output would move that pulse by a cycle, and a wrong tap would change the pulse count in a four-period window. It checks the three-edge latency of pin events and the polarity of each edge mode. A polarity swap would count the wrong transition, and a missing synchronizer stage would shift the pulse. It switches into an edge mode with the pin already high, which catches a tracker that only runs while selected because that tracker emits a spurious count. It also sends a one-cycle pin pulse and holds the prescaler clear for many periods, which catch double counting and taps that leak through the clear.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'b000,
        SRC_DIRECT   = 3'b001,
        SRC_DIV8     = 3'b010,
        SRC_DIV64    = 3'b011,
        SRC_DIV256   = 3'b100,
        SRC_DIV1024  = 3'b101,
        SRC_PIN_FALL = 3'b110,
        SRC_PIN_RISE = 3'b111
    } src_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    localparam int SRC_NTAP = 4;

    // log2 of each divider, slowest last
    function automatic int tap_log(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_psc_ctr.sv
module tmr_psc_ctr
    import tmr_clk_pkg::*;
#(
    parameter int NTAP = SRC_NTAP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [NTAP-1:0] tap_hit
);

    localparam int PSC_W = tap_log(NTAP - 1);

    logic [PSC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // each tap strobes when its low bits have all reached one
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int LW = tap_log(i);
        assign tap_hit[i] = !clr && (&cnt_q[LW-1:0]);
    end

    AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R8

    AST_DIV8_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tap_hit[0] |=> !tap_hit[0]); // R3

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_rise,
    output logic pin_fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    lvl_e                   lvl_q;
    lvl_e                   lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    // next state and event outputs
    always_comb begin
        lvl_d    = lvl_q;
        pin_rise = 1'b0;
        pin_fall = 1'b0;
        unique case (lvl_q)
            LVL_LOW: begin
                if (pin_s) begin
                    lvl_d    = LVL_HIGH;
                    pin_rise = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!pin_s) begin
                    lvl_d    = LVL_LOW;
                    pin_fall = 1'b1;
                end
            end
        endcase
    end

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pin_rise, pin_fall})); // R9

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise); // R6

    AST_FALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall |=> !pin_fall); // R5

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
    import tmr_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psc_clr,
    input  logic [2:0] src_sel,
    input  logic       ext_pin,
    output logic       cnt_en
);

    logic [SRC_NTAP-1:0] tap_hit;
    logic                pin_rise;
    logic                pin_fall;
    logic                en_d;
    src_e                sel_e;

    assign sel_e = src_e'(src_sel);

    tmr_psc_ctr #(
        .NTAP (SRC_NTAP)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (psc_clr),
        .tap_hit (tap_hit)
    );

    tmr_pin_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (ext_pin),
        .pin_rise (pin_rise),
        .pin_fall (pin_fall)
    );

    always_comb begin
        en_d = 1'b0;
        unique case (sel_e)
            SRC_OFF:      en_d = 1'b0;
            SRC_DIRECT:   en_d = 1'b1;
            SRC_DIV8:     en_d = tap_hit[0];
            SRC_DIV64:    en_d = tap_hit[1];
            SRC_DIV256:   en_d = tap_hit[2];
            SRC_DIV1024:  en_d = tap_hit[3];
            SRC_PIN_FALL: en_d = pin_fall;
            SRC_PIN_RISE: en_d = pin_rise;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en <= 1'b0;
        end else begin
            cnt_en <= en_d;
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'b000) |=> !cnt_en); // R1

    AST_DIRECT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'b001) |=> cnt_en); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && (src_sel != 3'b001) && $stable(src_sel)) |=> !cnt_en); // R9

endmodule

// File: tb/tmr_clk_sel_bench.sv
module tmr_clk_sel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       psc_clr = 1'b0;
    logic [2:0] src_sel = 3'b001;
    logic       ext_pin = 1'b0;
    logic       cnt_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_clk_sel u_tmr_clk_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .psc_clr (psc_clr),
        .src_sel (src_sel),
        .ext_pin (ext_pin),
        .cnt_en  (cnt_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // count pulses over n cycles, report index of first
    task automatic watch(input int n, output int first, output int cnt);
        first = -1;
        cnt = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (cnt_en) begin
                cnt++;
                if (first < 0) first = k;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cnt_en == 1'b0, "R10 reset cnt_en", int'(cnt_en), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_off();
        int first, cnt;
        @(negedge clk);
        src_sel = 3'b000;
        ext_pin = 1'b1;
        watch(10, first, cnt);
        ext_pin = 1'b0;
        watch(20, first, cnt);
        chk(cnt == 0, "R1 stopped pulses", cnt, 0);
    endtask

    task automatic t_direct();
        int first, cnt;
        @(negedge clk);
        src_sel = 3'b001;
        watch(20, first, cnt);
        chk(cnt == 20, "R2 direct pulses", cnt, 20);
    endtask

    task automatic t_div(input logic [2:0] code, input int n, input string tag);
        int first, cnt;
        @(negedge clk);
        src_sel = code;
        psc_clr = 1'b1;
        @(negedge clk);
        psc_clr = 1'b0;
        watch(4 * n, first, cnt);
        chk(first == n, {tag, " first pulse"}, first, n);
        chk(cnt == 4, {tag, " pulses in 4 periods"}, cnt, 4);
    endtask

    task automatic t_clr_hold();
        int first, cnt;
        @(negedge clk);
        src_sel = 3'b010;
        psc_clr = 1'b1;
        watch(40, first, cnt);
        chk(cnt == 0, "R8 pulses while clear held", cnt, 0);
        psc_clr = 1'b0;
        watch(8, first, cnt);
        chk(first == 8, "R8 first pulse after clear", first, 8);
    endtask

    task automatic pin_event(input logic val, input int exp_first, input int exp_cnt,
                             input string tag);
        int first, cnt;
        @(negedge clk);
        ext_pin = val;
        watch(8, first, cnt);
        chk(cnt == exp_cnt, {tag, " pulse count"}, cnt, exp_cnt);
        if (exp_cnt > 0) chk(first == exp_first, {tag, " latency"}, first, exp_first);
    endtask

    task automatic t_rise();
        int first, cnt;
        @(negedge clk);
        ext_pin = 1'b0;
        src_sel = 3'b111;
        watch(6, first, cnt);
        pin_event(1'b1, 3, 1, "R6 rise");
        pin_event(1'b0, 0, 0, "R6 fall ignored");
    endtask

    task automatic t_fall();
        int first, cnt;
        @(negedge clk);
        src_sel = 3'b110;
        watch(6, first, cnt);
        pin_event(1'b1, 0, 0, "R5 rise ignored");
        pin_event(1'b0, 3, 1, "R5 fall");
    endtask

    task automatic t_track();
        int first, cnt;
        @(negedge clk);
        src_sel = 3'b000;
        ext_pin = 1'b1;
        watch(10, first, cnt);
        src_sel = 3'b111;
        watch(10, first, cnt);
        chk(cnt == 0, "R7 no pulse on mode switch", cnt, 0);
        ext_pin = 1'b0;
        watch(6, first, cnt);
        pin_event(1'b1, 3, 1, "R7 new rise after switch");
    endtask

    task automatic t_short();
        int first, cnt;
        @(negedge clk);
        src_sel = 3'b111;
        ext_pin = 1'b0;
        watch(6, first, cnt);
        ext_pin = 1'b1;
        @(negedge clk);
        ext_pin = 1'b0;
        watch(9, first, cnt);
        chk(cnt == 1, "R9 short pulse rise count", cnt, 1);
        @(negedge clk);
        src_sel = 3'b110;
        watch(6, first, cnt);
        ext_pin = 1'b1;
        @(negedge clk);
        ext_pin = 1'b0;
        watch(9, first, cnt);
        chk(cnt == 1, "R9 short pulse fall count", cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_off();
        t_direct();
        t_div(3'b010, 8, "R3 div8");
        t_div(3'b011, 64, "R4 div64");
        t_div(3'b100, 256, "R4 div256");
        t_div(3'b101, 1024, "R4 div1024");
        t_clr_hold();
        t_rise();
        t_fall();
        t_track();
        t_short();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule